// File: doc/BRIEF.md
# Overclocking Frequency Watchdog

This block guards a software change of the clock frequency. Once software takes over frequency selection (software mode) and enables the watchdog, it must keep restarting the countdown. If the countdown runs out, the block either raises a soft alarm flag or performs a hard alarm. A hard alarm hands frequency selection back to the hardware-latched strap value and clears the software-mode bit, so a hung system returns to a known-safe frequency.

The countdown is measured in base units taken from the system clock by a prescaler. A configuration bit picks a short unit of `BASE_CYCLES` clocks or a long unit of `BASE_CYCLES * LONG_FACTOR` clocks. With the defaults at 100 MHz these units are 290 ms and 1160 ms. A 3-bit field sets how many units make one timeout.

A power-down input turns the watchdog off while it is asserted. If the re-arm bit is set, the watchdog turns itself back on when power-down ends. The register bus that drives the write strobes, and the synthesizer that consumes `fs_sel`, are outside this block.

Top module: `fs_watchdog`

## Requirements
- R1: After reset, `wd_en`, `hard_alarm`, `soft_alarm` and `sw_mode` are 0, `fs_sel` equals `hw_fs`, the timer field is 7, the short base is selected, the alarm mode is hard-only and re-arm is off. Enabling without writing the timer therefore expires after 7 short units.
- R2: With the short base, a timer value T (1..7) expires T*BASE_CYCLES clock edges after the edge that loaded the countdown. Expiry is visible from that edge onward.
- R3: With the long base (`ctl_long_base`=1), expiry comes T*BASE_CYCLES*LONG_FACTOR edges after the load.
- R4: A timer value of 0 expires after exactly one base unit, the same as a value of 1.
- R5: With `ctl_soft_first`=1, the first expiry sets `soft_alarm` and restarts the countdown from the timer field. The next expiry performs a hard alarm. With `ctl_soft_first`=0, the first expiry performs a hard alarm.
- R6: A hard alarm sets `hard_alarm`, clears `sw_mode` at the same edge (this overrides a mode write in that cycle), so that `fs_sel` equals `hw_fs`. The countdown then halts, and a kick does not restart it.
- R7: `hard_alarm` and `soft_alarm` stay set while the watchdog stays enabled. They read 0 from the edge at which the watchdog becomes disabled, and after reset.
- R8: A `kick` pulse, a timer write (`tmr_we`) or a control write (`ctl_we`) restarts both the prescaler and the countdown. A kick in the same cycle as an expiry cancels the expiry.
- R9: While `pwr_down` is 1, `wd_en` reads 0 from the next edge and nothing counts. At the first edge with `pwr_down` back at 0, `wd_en` becomes 1 and a fresh countdown starts if the re-arm bit is set. Otherwise `wd_en` stays 0.
- R10: A mode write loads `sw_mode` and the software select value. `fs_sel` shows the software value while `sw_mode` is 1, and `hw_fs` (combinationally) while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Write strobe for enable, alarm mode, base and re-arm; restarts the countdown |
| ctl_en | input | 1 | Watchdog enable value |
| ctl_soft_first | input | 1 | 0: hard alarm only; 1: soft alarm first, then hard |
| ctl_long_base | input | 1 | 0: short base unit; 1: long base unit |
| ctl_rearm_pd | input | 1 | Re-enable the watchdog when power-down ends |
| tmr_we | input | 1 | Write strobe for the timer field; restarts the countdown |
| tmr_val | input | 3 | Timeout in base units |
| mode_we | input | 1 | Write strobe for software mode and software select |
| mode_sw | input | 1 | Software mode value |
| mode_fs | input | FS_W | Software frequency select value |
| hw_fs | input | FS_W | Hardware-latched frequency select |
| kick | input | 1 | Restart pulse |
| pwr_down | input | 1 | Power-down level |
| wd_en | output | 1 | Watchdog enable state |
| hard_alarm | output | 1 | Hard alarm status |
| soft_alarm | output | 1 | Soft alarm status |
| sw_mode | output | 1 | Software mode state |
| fs_sel | output | FS_W | Effective frequency select |

## Verification
The hardest states to reach are the ones that depend on the order of events: the hard alarm that follows a soft alarm after a second full countdown, and the automatic re-enable when power-down ends. The stimulus reaches the first by writing a timer of 1 with a short prescaler and waiting through two expiries without a kick. It reaches the second by asserting power-down in the middle of a countdown with re-arm set, holding it far longer than a timeout, and then timing the fresh countdown from the release edge. A reference model in the bench follows the ports on every clock, so the clearing, halting and override orderings are checked at each cycle between the directed points.

// File: rtl/fswd_pkg.sv
// Package: shared field widths, reset values and encodings of the
// frequency watchdog. Assumes a fixed 3-bit timer field.
package fswd_pkg;
    localparam int TMR_W = 3;
    localparam logic [TMR_W-1:0] TMR_RESET = 3'd7;

    typedef logic [TMR_W-1:0] tmr_t;

    // Alarm policy picked by the soft-first control bit
    typedef enum logic {
        ALM_HARD_ONLY  = 1'b0,
        ALM_SOFT_FIRST = 1'b1
    } alarm_mode_e;
endpackage

// File: rtl/fswd_prescaler.sv
// Prescaler: divides the clock into base-unit ticks. The unit is
// BASE_CYCLES clocks, or BASE_CYCLES*LONG_FACTOR when long_base is set.
// Assumes long_base only changes in a cycle where restart is high.
module fswd_prescaler #(
    parameter int BASE_CYCLES = 29_000_000,
    parameter int LONG_FACTOR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic long_base,
    output logic tick
);
    localparam int LONG_CYCLES = BASE_CYCLES * LONG_FACTOR;
    localparam int CW = (LONG_CYCLES > 1) ? $clog2(LONG_CYCLES) : 1;

    logic [CW-1:0] pcnt;
    logic [CW-1:0] lim_m1;

    // Last count value of the selected unit
    always_comb begin
        lim_m1 = long_base ? CW'(LONG_CYCLES - 1) : CW'(BASE_CYCLES - 1);
    end

    assign tick = run && (pcnt == lim_m1);

    // Cycle counter within one base unit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart || !run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assert_presc_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= lim_m1)
        else $error("prescaler beyond selected unit");
endmodule

// File: rtl/fswd_countdown.sv
// Countdown: counts base ticks down from the timer field. A value of 0
// or 1 expires on the first tick. A load cancels an expiry in the same cycle.
// After an expiry it reloads only when reload_on_exp is high.
module fswd_countdown
    import fswd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  tmr_t load_val,
    input  logic tick,
    input  logic reload_on_exp,
    output logic expire
);
    tmr_t cnt;

    assign expire = tick && !load && (cnt <= tmr_t'(1));

    // Remaining units of the current timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= TMR_RESET;
        end else if (load) begin
            cnt <= load_val;
        end else if (expire) begin
            if (reload_on_exp) begin
                cnt <= load_val;
            end
        end else if (tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_load_takes_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)))
        else $error("countdown did not take load value");
endmodule

// File: rtl/fswd_alarm.sv
// Alarm: holds the soft/hard status and the software frequency mode,
// and selects the effective frequency select. Assumes expire is high for
// one cycle per timeout and that keep is the next-cycle enable.
module fswd_alarm
    import fswd_pkg::*;
#(
    parameter int FS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            expire,
    input  alarm_mode_e     policy,
    input  logic            keep,
    input  logic            mode_we,
    input  logic            mode_sw,
    input  logic [FS_W-1:0] mode_fs,
    input  logic [FS_W-1:0] hw_fs,
    output logic            hard_q,
    output logic            soft_q,
    output logic            soft_step,
    output logic            sw_q,
    output logic [FS_W-1:0] fs_sel
);
    logic [FS_W-1:0] sw_fs_q;
    logic            hard_event;

    assign soft_step  = expire && (policy == ALM_SOFT_FIRST) && !soft_q;
    assign hard_event = expire && !soft_step;

    // Alarm status: set on expiry, cleared when the watchdog turns off
    always_ff @(posedge clk) begin
        if (!rst_n || !keep) begin
            hard_q <= 1'b0;
            soft_q <= 1'b0;
        end else if (soft_step) begin
            soft_q <= 1'b1;
        end else if (hard_event) begin
            hard_q <= 1'b1;
        end
    end

    // Software mode register; a hard alarm wins over a mode write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q    <= 1'b0;
            sw_fs_q <= '0;
        end else begin
            if (hard_event) begin
                sw_q <= 1'b0;
            end else if (mode_we) begin
                sw_q <= mode_sw;
            end
            if (mode_we) begin
                sw_fs_q <= mode_fs;
            end
        end
    end

    // Effective frequency select
    always_comb begin
        fs_sel = sw_q ? sw_fs_q : hw_fs;
    end

    assert_hard_drops_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_q) |-> (!sw_q && fs_sel == hw_fs))
        else $error("hard alarm left software mode on");

    assert_soft_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hard_q) && policy == ALM_SOFT_FIRST) |-> soft_q)
        else $error("hard alarm before soft alarm");

    assert_status_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_q && keep) |=> hard_q)
        else $error("hard status dropped while enabled");
endmodule

// File: rtl/fs_watchdog.sv
// Top: frequency watchdog. Holds the control and timer fields, sequences
// enable across power-down, and ties prescaler, countdown and alarm.
// Assumes single-cycle write strobes from an external register bus.
module fs_watchdog
    import fswd_pkg::*;
#(
    parameter int BASE_CYCLES = 29_000_000,
    parameter int LONG_FACTOR = 4,
    parameter int FS_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic            ctl_en,
    input  logic            ctl_soft_first,
    input  logic            ctl_long_base,
    input  logic            ctl_rearm_pd,
    input  logic            tmr_we,
    input  logic [2:0]      tmr_val,
    input  logic            mode_we,
    input  logic            mode_sw,
    input  logic [FS_W-1:0] mode_fs,
    input  logic [FS_W-1:0] hw_fs,
    input  logic            kick,
    input  logic            pwr_down,
    output logic            wd_en,
    output logic            hard_alarm,
    output logic            soft_alarm,
    output logic            sw_mode,
    output logic [FS_W-1:0] fs_sel
);
    logic        en_q;
    alarm_mode_e policy_q;
    logic        long_q;
    logic        rearm_q;
    tmr_t        tmr_q;
    logic        pd_q;

    logic        en_nxt;
    logic        pd_exit_arm;
    logic        load;
    logic        run;
    tmr_t        load_val;
    logic        tick;
    logic        expire;
    logic        soft_step;
    logic        hard_q;
    logic        soft_q;

    assign pd_exit_arm = pd_q && !pwr_down && rearm_q;
    assign load        = kick || tmr_we || ctl_we || pd_exit_arm;
    assign run         = en_q && !pwr_down && !hard_q;
    assign load_val    = tmr_we ? tmr_val : tmr_q;

    // Next enable: power-down, then control write, then re-arm
    always_comb begin
        if (pwr_down) begin
            en_nxt = 1'b0;
        end else if (ctl_we) begin
            en_nxt = ctl_en;
        end else if (pd_exit_arm) begin
            en_nxt = 1'b1;
        end else begin
            en_nxt = en_q;
        end
    end

    // Control and timer fields plus power-down history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            policy_q <= ALM_HARD_ONLY;
            long_q   <= 1'b0;
            rearm_q  <= 1'b0;
            tmr_q    <= TMR_RESET;
            pd_q     <= 1'b0;
        end else begin
            en_q <= en_nxt;
            pd_q <= pwr_down;
            if (ctl_we) begin
                policy_q <= alarm_mode_e'(ctl_soft_first);
                long_q   <= ctl_long_base;
                rearm_q  <= ctl_rearm_pd;
            end
            if (tmr_we) begin
                tmr_q <= tmr_val;
            end
        end
    end

    fswd_prescaler #(
        .BASE_CYCLES (BASE_CYCLES),
        .LONG_FACTOR (LONG_FACTOR)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (load),
        .long_base (long_q),
        .tick      (tick)
    );

    fswd_countdown u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .load_val      (load_val),
        .tick          (tick),
        .reload_on_exp (soft_step),
        .expire        (expire)
    );

    fswd_alarm #(
        .FS_W (FS_W)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .policy    (policy_q),
        .keep      (en_nxt),
        .mode_we   (mode_we),
        .mode_sw   (mode_sw),
        .mode_fs   (mode_fs),
        .hw_fs     (hw_fs),
        .hard_q    (hard_q),
        .soft_q    (soft_q),
        .soft_step (soft_step),
        .sw_q      (sw_mode),
        .fs_sel    (fs_sel)
    );

    assign wd_en      = en_q;
    assign hard_alarm = hard_q;
    assign soft_alarm = soft_q;

    assert_pd_clears_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !wd_en)
        else $error("enable survived power-down");

    assert_alarm_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_alarm || soft_alarm) |-> wd_en)
        else $error("alarm status while disabled");
endmodule

// File: tb/fs_watchdog_test.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks at the timing corners.
module fs_watchdog_test;
    localparam int B  = 3;
    localparam int LF = 4;
    localparam int FW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, ctl_en = 0, ctl_soft_first = 0, ctl_long_base = 0, ctl_rearm_pd = 0;
    logic tmr_we = 0;
    logic [2:0] tmr_val = 0;
    logic mode_we = 0, mode_sw = 0;
    logic [FW-1:0] mode_fs = 0, hw_fs = 3'd2;
    logic kick = 0, pwr_down = 0;
    logic wd_en, hard_alarm, soft_alarm, sw_mode;
    logic [FW-1:0] fs_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fs_watchdog #(.BASE_CYCLES(B), .LONG_FACTOR(LF), .FS_W(FW)) uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_soft_first(ctl_soft_first),
        .ctl_long_base(ctl_long_base), .ctl_rearm_pd(ctl_rearm_pd),
        .tmr_we(tmr_we), .tmr_val(tmr_val),
        .mode_we(mode_we), .mode_sw(mode_sw), .mode_fs(mode_fs),
        .hw_fs(hw_fs), .kick(kick), .pwr_down(pwr_down),
        .wd_en(wd_en), .hard_alarm(hard_alarm), .soft_alarm(soft_alarm),
        .sw_mode(sw_mode), .fs_sel(fs_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_en, m_both, m_long, m_rearm, m_tmr, m_pdq, m_p, m_cnt, m_hard, m_soft, m_sw, m_swfs;
    bit m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_both = 0; m_long = 0; m_rearm = 0; m_tmr = 7; m_pdq = 0;
            m_p = 0; m_cnt = 7; m_hard = 0; m_soft = 0; m_sw = 0; m_swfs = 0;
            m_valid = 1;
        end else begin
            int lim, run, tck, ld, exp_ev, en_n, exit_arm, soft_ev, hard_ev, lv;
            lim = m_long ? B * LF : B;
            run = m_en && !pwr_down && !m_hard;
            tck = run && (m_p == lim - 1);
            exit_arm = m_pdq && !pwr_down && m_rearm;
            ld = kick || tmr_we || ctl_we || exit_arm;
            lv = tmr_we ? int'(tmr_val) : m_tmr;
            exp_ev = tck && !ld && (m_cnt <= 1);
            if (pwr_down) en_n = 0;
            else if (ctl_we) en_n = ctl_en;
            else if (exit_arm) en_n = 1;
            else en_n = m_en;
            soft_ev = exp_ev && m_both && !m_soft;
            hard_ev = exp_ev && !soft_ev;
            if (!en_n) begin m_hard = 0; m_soft = 0; end
            else if (soft_ev) m_soft = 1;
            else if (hard_ev) m_hard = 1;
            if (hard_ev) m_sw = 0;
            else if (mode_we) m_sw = mode_sw;
            if (mode_we) m_swfs = int'(mode_fs);
            if (ld) m_cnt = lv;
            else if (soft_ev) m_cnt = lv;
            else if (tck && !exp_ev) m_cnt = m_cnt - 1;
            if (ld || !run || tck) m_p = 0; else m_p = m_p + 1;
            if (ctl_we) begin m_both = ctl_soft_first; m_long = ctl_long_base; m_rearm = ctl_rearm_pd; end
            if (tmr_we) m_tmr = int'(tmr_val);
            m_en = en_n;
            m_pdq = pwr_down;
        end
    end

    // Per-clock comparison, after the edge has settled
    always begin
        @(posedge clk);
        #2;
        if (m_valid && rst_n) begin
            chk("R9 model wd_en", int'(wd_en), m_en);
            chk("R7 model hard_alarm", int'(hard_alarm), m_hard);
            chk("R5 model soft_alarm", int'(soft_alarm), m_soft);
            chk("R10 model fs_sel", int'(fs_sel), m_sw ? m_swfs : int'(hw_fs));
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog on the bench itself
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog all R1: actual hung expected done");
            finish_run();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl(input logic en, input logic both, input logic lng, input logic rearm);
        ctl_we = 1; ctl_en = en; ctl_soft_first = both; ctl_long_base = lng; ctl_rearm_pd = rearm;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic tmr(input int v);
        tmr_we = 1; tmr_val = 3'(v);
        @(negedge clk);
        tmr_we = 0;
    endtask

    task automatic kick_p();
        kick = 1;
        @(negedge clk);
        kick = 0;
    endtask

    task automatic mode(input logic sw, input int fs);
        mode_we = 1; mode_sw = sw; mode_fs = 3'(fs);
        @(negedge clk);
        mode_we = 0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 wd_en", int'(wd_en), 0);
        chk("R1 hard", int'(hard_alarm), 0);
        chk("R1 soft", int'(soft_alarm), 0);
        chk("R1 sw_mode", int'(sw_mode), 0);
        chk("R1 fs_sel", int'(fs_sel), 2);

        // R10 software selection
        mode(1, 5);
        chk("R10 fs_sel sw", int'(fs_sel), 5);

        // R1/R2 default timer 7 with short base, hard-only
        ctl(1, 0, 0, 0);
        wait_cyc(7 * B - 1);
        chk("R2 before expiry", int'(hard_alarm), 0);
        wait_cyc(1);
        chk("R1 default timeout hard", int'(hard_alarm), 1);
        chk("R6 fs back to hw", int'(fs_sel), 2);
        chk("R6 sw_mode cleared", int'(sw_mode), 0);
        kick_p();
        wait_cyc(10);
        chk("R6 halted after kick", int'(hard_alarm), 1);
        ctl(0, 0, 0, 0);
        chk("R7 hard cleared on disable", int'(hard_alarm), 0);

        // R3 long base
        tmr(2);
        ctl(1, 0, 1, 0);
        wait_cyc(2 * B * LF - 1);
        chk("R3 before long expiry", int'(hard_alarm), 0);
        wait_cyc(1);
        chk("R3 long expiry", int'(hard_alarm), 1);
        ctl(0, 0, 0, 0);

        // R4 timer 0
        tmr(0);
        ctl(1, 0, 0, 0);
        wait_cyc(B - 1);
        chk("R4 before", int'(hard_alarm), 0);
        wait_cyc(1);
        chk("R4 one unit", int'(hard_alarm), 1);
        ctl(0, 0, 0, 0);

        // R5 soft then hard
        tmr(1);
        ctl(1, 1, 0, 0);
        wait_cyc(B - 1);
        chk("R5 soft early", int'(soft_alarm), 0);
        wait_cyc(1);
        chk("R5 soft set", int'(soft_alarm), 1);
        chk("R5 hard not yet", int'(hard_alarm), 0);
        wait_cyc(B);
        chk("R5 hard second", int'(hard_alarm), 1);
        wait_cyc(5);
        chk("R7 soft kept", int'(soft_alarm), 1);
        ctl(0, 0, 0, 0);
        chk("R7 soft cleared", int'(soft_alarm), 0);

        // R8 kick restarts
        tmr(2);
        ctl(1, 0, 0, 0);
        wait_cyc(4);
        kick_p();
        wait_cyc(2 * B - 1);
        chk("R8 kick postpones", int'(hard_alarm), 0);
        wait_cyc(1);
        chk("R8 expiry after kick", int'(hard_alarm), 1);
        ctl(0, 0, 0, 0);

        // R8 timer write restarts
        ctl(1, 0, 0, 0);
        wait_cyc(4);
        tmr(3);
        wait_cyc(3 * B - 1);
        chk("R8 timer write postpones", int'(hard_alarm), 0);
        wait_cyc(1);
        chk("R8 expiry after timer write", int'(hard_alarm), 1);
        ctl(0, 0, 0, 0);

        // R9 power-down with re-arm
        mode(1, 6);
        ctl(1, 0, 0, 1);
        wait_cyc(2);
        pwr_down = 1;
        wait_cyc(1);
        chk("R9 pd disables", int'(wd_en), 0);
        wait_cyc(30);
        chk("R9 no alarm in pd", int'(hard_alarm), 0);
        chk("R10 sw kept in pd", int'(fs_sel), 6);
        pwr_down = 0;
        wait_cyc(1);
        chk("R9 rearmed", int'(wd_en), 1);
        wait_cyc(3 * B - 1);
        chk("R9 fresh count", int'(hard_alarm), 0);
        wait_cyc(1);
        chk("R9 expiry after rearm", int'(hard_alarm), 1);
        ctl(0, 0, 0, 0);

        // R9 power-down without re-arm
        ctl(1, 0, 0, 0);
        pwr_down = 1;
        wait_cyc(3);
        pwr_down = 0;
        wait_cyc(2);
        chk("R9 stays off", int'(wd_en), 0);

        // R10 hardware path follows hw_fs
        mode(0, 1);
        hw_fs = 3'd6;
        #1;
        chk("R10 fs follows hw", int'(fs_sel), 6);
        wait_cyc(3);
        finish_run();
    end
endmodule